// File: doc/BRIEF.md
# Watchdog and Interval Timer with Overflow Output

This peripheral holds an 8-bit up-counter that advances on one of eight prescaled ticks of the system clock. Software reaches it through a small register port with three locations: the count, a control/status word, and a reset-control word. In watchdog mode the counter must be rewritten before it wraps. If it wraps, an active-low overflow line drops for a fixed number of ticks, the timer stops and clears itself, and a chip reset request may be raised. In interval mode a wrap sets a flag, pulses an interrupt and the count carries on.

While the overflow line is low, all register writes are locked out. The watchdog overflow flag clears only through a two-step handshake: a read of the control/status word, then a write of 0 to the flag. Both steps must happen after the line has gone high again.

The block also decides how a CPU sleep request is served. When a running watchdog would lose its clock, a request for software standby is turned into plain sleep.

Top module: `wdt_core`

## Requirements
- R1: After reset, all three registers read 0x00, the overflow line `ovf_n_o` is high, and `rst_req_o` and `irq_o` are low.
- R2: Register addresses are 0 for the count, 1 for control/status and 2 for reset-control. A count write takes effect only with key 0x5A in `bus_wdata[15:8]`, and a control/status write only with key 0xA5 there. A write with a wrong key changes nothing. Reset-control takes no key, and its bit 0 is the reset enable. Control/status bits: 7 is the watchdog overflow flag, 6 is the mode (1 = watchdog, 0 = interval), 5 is run, 4 is the interval flag, 3 reads 0, and 2:0 select the tap.
- R3: While run is 1, the count rises by one on each tick of the selected tap. Taps 0 to 7 divide the system clock by 2, 64, 128, 512, 2048, 8192, 32768 and 131072.
- R4: In interval mode, a wrap from 0xFF sets the interval flag and raises `irq_o` for exactly one clock. The count wraps to 0 and keeps counting. `ovf_n_o` stays high and no reset is requested.
- R5: In watchdog mode, a wrap drives `ovf_n_o` low for 132 ticks of the tap in use at the wrap, which is 264 clocks on tap 0.
- R6: When the reset enable is 1, a watchdog wrap raises `rst_req_o` on the same edge on which `ovf_n_o` falls, for exactly 518 clocks.
- R7: On a watchdog wrap the count clears to 0 and control/status reads 0x80, whatever the reset enable is. When the reset enable is 0, `rst_req_o` stays low.
- R8: While `ovf_n_o` is low, writes to all three registers are ignored, even with the correct key.
- R9: A read of control/status made while `ovf_n_o` is low does not count as the first step of the flag clear.
- R10: The watchdog overflow flag clears only when a control/status write with bit 7 = 0 follows a read of control/status, both after `ovf_n_o` has returned high. A write with no such read leaves the flag set. Writing 1 to bit 7 never sets it.
- R11: Writing 0 to bit 4 of control/status clears the interval flag. Writing 1 to it has no effect.
- R12: When `sleep_req_i` is high, `standby_o` is high only if `sby_sel_i` is 1 and the timer is either stopped or in interval mode. In every other case `sleep_o` is high instead. The two outputs are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe, one clock |
| bus_rd | input | 1 | Register read strobe, one clock |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Key in the upper byte, data in the lower byte |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high |
| sby_sel_i | input | 1 | Standby selected for the next sleep request |
| sleep_req_i | input | 1 | CPU sleep request |
| sleep_o | output | 1 | Request is served as sleep |
| standby_o | output | 1 | Request is served as software standby |
| ovf_n_o | output | 1 | Active-low watchdog overflow line |
| rst_req_o | output | 1 | Internal chip reset request |
| irq_o | output | 1 | Interval interrupt pulse |

## Verification
The hardest part to reach is the window in which `ovf_n_o` is low. Inside it, writes, keys and a read of the flag must all fail, and after it the flag must clear only through a fresh read followed by a write. The stimulus gets there quickly by preloading the count to 0xF0 on the divide-by-2 tap. It then issues keyed writes and a control/status read while the line is still low. After release it walks the clear sequence: a write without a read, a write of 1 to the flag, and finally a read followed by a write of 0.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int NUM_TAPS  = 8;
  localparam int TAP_SEL_W = $clog2(NUM_TAPS);

  localparam logic [1:0] ADDR_CNT  = 2'd0;
  localparam logic [1:0] ADDR_CTL  = 2'd1;
  localparam logic [1:0] ADDR_RCTL = 2'd2;

  localparam logic [7:0] KEY_CNT = 8'h5A;
  localparam logic [7:0] KEY_CTL = 8'hA5;

  typedef struct packed {
    logic       wd_flag;
    logic       wd_mode;
    logic       run;
    logic       ivl_flag;
    logic       rsvd;
    logic [2:0] tap;
  } ctl_t;

  // Prescaler tap index -> log2 of the division ratio.
  function automatic int tap_exp(input int idx);
    case (idx)
      0:       return 1;
      1:       return 6;
      2:       return 7;
      3:       return 9;
      4:       return 11;
      5:       return 13;
      6:       return 15;
      default: return 17;
    endcase
  endfunction

  // Standby only when the watchdog cannot lose its clock while counting.
  function automatic logic pick_standby(input logic req, input logic sby,
                                        input logic run, input logic wd);
    return req & sby & (~run | ~wd);
  endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int NTAP  = wdt_pkg::NUM_TAPS,
  parameter int PRE_W = wdt_pkg::tap_exp(wdt_pkg::NUM_TAPS - 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [NTAP-1:0] tick_o
);
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  // A tap ticks once per period, when its low bits are all ones.
  for (genvar i = 0; i < NTAP; i++) begin : g_tap
    localparam int E = wdt_pkg::tap_exp(i);
    assign tick_o[i] = &pre_q[E-1:0];
  end
endmodule

// File: rtl/wdt_hold_timer.sv
module wdt_hold_timer #(
  parameter int LOAD = 132
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic step_i,
  output logic busy_o
);
  localparam int CW = $clog2(LOAD + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt_q <= '0;
    else if (start_i)                 cnt_q <= CW'(LOAD);
    else if (step_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/wdt_lp_arb.sv
module wdt_lp_arb (
  input  logic sleep_req_i,
  input  logic sby_sel_i,
  input  logic run_i,
  input  logic wd_mode_i,
  output logic sleep_o,
  output logic standby_o
);
  logic stby;
  assign stby      = wdt_pkg::pick_standby(sleep_req_i, sby_sel_i, run_i, wd_mode_i);
  assign standby_o = stby;
  assign sleep_o   = sleep_req_i & ~stby;
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int DATA_W     = 8,
  parameter int HOLD_TICKS = 132,
  parameter int RST_CLKS   = 518
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [1:0]          bus_addr,
  input  logic [2*DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic                sby_sel_i,
  input  logic                sleep_req_i,
  output logic                sleep_o,
  output logic                standby_o,
  output logic                ovf_n_o,
  output logic                rst_req_o,
  output logic                irq_o
);
  import wdt_pkg::*;

  localparam int TW = TAP_SEL_W;

  // Register state
  logic [DATA_W-1:0] cnt_q;
  logic              wd_flag_q, wd_mode_q, run_q, ivl_flag_q, rsten_q, armed_q, irq_q;
  logic [TW-1:0]     tap_q, hold_tap_q;

  // Named internal events
  logic [NUM_TAPS-1:0] tick_all;
  logic tick_sel, hold_step, ovf_evt, wd_ovf, ivl_ovf, locked;
  logic hold_busy, rst_busy;
  logic wr_cnt_ok, wr_ctl_ok, wr_rctl_ok, rd_ctl_arm;
  logic [DATA_W-1:0] wr_key, wr_data;
  ctl_t wr_ctl, ctl_view;

  wdt_prescaler #(.NTAP(NUM_TAPS), .PRE_W(tap_exp(NUM_TAPS - 1))) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_o(tick_all)
  );

  assign tick_sel  = tick_all[tap_q];
  assign hold_step = tick_all[hold_tap_q];
  assign ovf_evt   = run_q & tick_sel & (cnt_q == {DATA_W{1'b1}});
  assign wd_ovf    = ovf_evt & wd_mode_q;
  assign ivl_ovf   = ovf_evt & ~wd_mode_q;

  wdt_hold_timer #(.LOAD(HOLD_TICKS)) u_ovf_hold (
    .clk(clk), .rst_n(rst_n), .start_i(wd_ovf), .step_i(hold_step), .busy_o(hold_busy)
  );

  wdt_hold_timer #(.LOAD(RST_CLKS)) u_rst_hold (
    .clk(clk), .rst_n(rst_n), .start_i(wd_ovf & rsten_q), .step_i(1'b1), .busy_o(rst_busy)
  );

  assign locked = hold_busy;

  // Bus decode
  assign wr_key     = bus_wdata[2*DATA_W-1:DATA_W];
  assign wr_data    = bus_wdata[DATA_W-1:0];
  assign wr_ctl     = ctl_t'(wr_data);
  assign wr_cnt_ok  = bus_wr & ~locked & (bus_addr == ADDR_CNT)  & (wr_key == KEY_CNT);
  assign wr_ctl_ok  = bus_wr & ~locked & (bus_addr == ADDR_CTL)  & (wr_key == KEY_CTL);
  assign wr_rctl_ok = bus_wr & ~locked & (bus_addr == ADDR_RCTL);
  assign rd_ctl_arm = bus_rd & ~locked & (bus_addr == ADDR_CTL) & wd_flag_q;

  // Counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (wd_ovf)           cnt_q <= '0;
    else if (wr_cnt_ok)        cnt_q <= wr_data;
    else if (run_q && tick_sel) cnt_q <= cnt_q + 1'b1;
  end

  // Control fields
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_mode_q <= 1'b0;
      run_q     <= 1'b0;
      tap_q     <= '0;
    end else if (wd_ovf) begin
      wd_mode_q <= 1'b0;
      run_q     <= 1'b0;
      tap_q     <= '0;
    end else if (wr_ctl_ok) begin
      wd_mode_q <= wr_ctl.wd_mode;
      run_q     <= wr_ctl.run;
      tap_q     <= wr_ctl.tap;
    end
  end

  // Interval flag: set by wrap, cleared by writing 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ivl_flag_q <= 1'b0;
    else if (wd_ovf)    ivl_flag_q <= 1'b0;
    else if (ivl_ovf)   ivl_flag_q <= 1'b1;
    else if (wr_ctl_ok) ivl_flag_q <= ivl_flag_q & wr_ctl.ivl_flag;
  end

  // Watchdog flag with read-then-write clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_flag_q <= 1'b0;
      armed_q   <= 1'b0;
    end else if (wd_ovf) begin
      wd_flag_q <= 1'b1;
      armed_q   <= 1'b0;
    end else if (wr_ctl_ok) begin
      if (armed_q && !wr_ctl.wd_flag) wd_flag_q <= 1'b0;
      armed_q <= 1'b0;
    end else if (rd_ctl_arm) begin
      armed_q <= 1'b1;
    end
  end

  // Reset-control, hold tap capture, interrupt
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsten_q    <= 1'b0;
      hold_tap_q <= '0;
      irq_q      <= 1'b0;
    end else begin
      if (wr_rctl_ok) rsten_q <= wr_data[0];
      if (wd_ovf)     hold_tap_q <= tap_q;
      irq_q <= ivl_ovf;
    end
  end

  assign ctl_view = '{wd_flag: wd_flag_q, wd_mode: wd_mode_q, run: run_q,
                      ivl_flag: ivl_flag_q, rsvd: 1'b0, tap: tap_q};

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        ADDR_CNT:  bus_rdata = cnt_q;
        ADDR_CTL:  bus_rdata = DATA_W'(ctl_view);
        ADDR_RCTL: bus_rdata = DATA_W'(rsten_q);
        default:   bus_rdata = '0;
      endcase
    end
  end

  wdt_lp_arb u_lp (
    .sleep_req_i(sleep_req_i), .sby_sel_i(sby_sel_i), .run_i(run_q),
    .wd_mode_i(wd_mode_q), .sleep_o(sleep_o), .standby_o(standby_o)
  );

  assign ovf_n_o   = ~hold_busy;
  assign rst_req_o = rst_busy;
  assign irq_o     = irq_q;
endmodule

// File: rtl/wdt_core_chk.sv
module wdt_core_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [1:0]        bus_addr,
  input logic              ovf_n,
  input logic              rst_req,
  input logic              irq,
  input logic              sleep_o,
  input logic              standby_o,
  input logic              run,
  input logic              wd_mode,
  input logic              rsten,
  input logic              wd_flag,
  input logic [DATA_W-1:0] cnt
);
  assert_rst_with_ovf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> (!ovf_n && $past(rsten)));

  assert_irq_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_irq_no_ovf_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ovf_n);

  assert_lock_rctl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd2 && !ovf_n) |=> $stable(rsten));

  assert_lock_cnt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0 && !ovf_n) |=> $stable(cnt));

  assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wd_flag) |-> ovf_n);

  assert_wd_halts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf_n) |-> (!run && cnt == '0 && wd_flag));

  assert_lp_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(sleep_o && standby_o));

  assert_lp_wd_R12: assert property (@(posedge clk) disable iff (!rst_n)
    standby_o |-> !(run && wd_mode));
endmodule

bind wdt_core wdt_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .ovf_n(ovf_n_o), .rst_req(rst_req_o), .irq(irq_o),
  .sleep_o(sleep_o), .standby_o(standby_o),
  .run(run_q), .wd_mode(wd_mode_q), .rsten(rsten_q), .wd_flag(wd_flag_q), .cnt(cnt_q)
);

// File: tb/wdt_core_test.sv
module wdt_core_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic sby_sel = 1'b0, sleep_req = 1'b0;
  logic sleep_o, standby_o, ovf_n, rst_req, irq;

  int n_tests = 0, n_fail = 0;

  always #10 clk = ~clk;

  wdt_core uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sby_sel_i(sby_sel),
    .sleep_req_i(sleep_req), .sleep_o(sleep_o), .standby_o(standby_o),
    .ovf_n_o(ovf_n), .rst_req_o(rst_req), .irq_o(irq)
  );

  // Pulse-width monitors
  int low_run = 0, last_low = 0, rst_run = 0, last_rst = 0, irq_run = 0, max_irq = 0;
  bit rst_seen = 0;
  always @(negedge clk) begin
    if (!ovf_n) low_run++;
    else if (low_run != 0) begin last_low = low_run; low_run = 0; end
    if (rst_req) begin rst_run++; rst_seen = 1; end
    else if (rst_run != 0) begin last_rst = rst_run; rst_run = 0; end
    if (irq) irq_run++;
    else begin if (irq_run > max_irq) max_irq = irq_run; irq_run = 0; end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_low(output bit ok);
    ok = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!ovf_n) begin ok = 1; break; end
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (ovf_n && !rst_req) break;
    end
    @(negedge clk);
  endtask

  // Vector table: addr[25:24], wdata[23:8], expected readback[7:0]
  localparam int NVEC = 8;
  localparam logic [25:0] VEC [NVEC] = '{
    {2'd0, 16'h5A33, 8'h33},   // R2 keyed count write
    {2'd0, 16'h0044, 8'h33},   // R2 wrong key discarded
    {2'd1, 16'hA507, 8'h07},   // R2 keyed control write
    {2'd1, 16'h5A01, 8'h07},   // R2 wrong key discarded
    {2'd2, 16'h0001, 8'h01},   // R2 reset-control, no key
    {2'd1, 16'hA590, 8'h00},   // R10/R11 writing 1 to flags sets nothing
    {2'd2, 16'h0000, 8'h00},   // R2
    {2'd0, 16'h5AFF, 8'hFF}    // R2
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    bit ok;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 ovf_n", ovf_n, 1);
    chk("R1 rst_req", rst_req, 0);
    chk("R1 irq", irq, 0);
    rd(2'd0, d); chk("R1 count", d, 0);
    rd(2'd1, d); chk("R1 control", d, 0);
    rd(2'd2, d); chk("R1 reset-control", d, 0);

    // R2 vector walk
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][25:24], VEC[i][23:8]);
      rd(VEC[i][25:24], d);
      chk($sformatf("R2 vector %0d", i), d, VEC[i][7:0]);
    end

    // R3 tap 1 (divide by 64): 640 clocks -> about 10 counts
    wr(2'd0, 16'h5A00);
    wr(2'd1, 16'hA521);
    repeat (638) @(negedge clk);
    wr(2'd1, 16'hA501);
    rd(2'd0, d);
    chk("R3 tap1 count in 9..11", (d >= 9 && d <= 11), 1);
    // R3 tap 7 (divide by 131072): no tick in 1000 clocks this early
    wr(2'd0, 16'h5A00);
    wr(2'd1, 16'hA527);
    repeat (1000) @(negedge clk);
    wr(2'd1, 16'hA500);
    rd(2'd0, d);
    chk("R3 tap7 count", (d <= 1), 1);

    // R4 interval wrap with reset enable set
    wr(2'd2, 16'h0001);
    wr(2'd0, 16'h5AF0);
    rst_seen = 0;
    wr(2'd1, 16'hA520);
    ok = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (irq) begin ok = 1; break; end
    end
    chk("R4 irq seen", ok, 1);
    chk("R4 ovf_n stays high", ovf_n, 1);
    rd(2'd1, d); chk("R4 interval flag", d, 8'h30);
    rd(2'd0, d); chk("R4 count wrapped and running", (d >= 1 && d <= 15), 1);
    chk("R4 irq width", max_irq, 1);
    chk("R4 no reset", rst_seen, 0);
    wr(2'd1, 16'hA520);
    rd(2'd1, d); chk("R11 interval flag cleared", d, 8'h20);
    wr(2'd1, 16'hA500);

    // R5/R6/R8/R9/R10 watchdog wrap with reset enabled
    wr(2'd0, 16'h5AF0);
    wr(2'd1, 16'hA560);
    wait_low(ok);
    chk("R5 overflow line fell", ok, 1);
    chk("R6 reset with overflow", rst_req, 1);
    rd(2'd0, d); chk("R7 count cleared", d, 0);
    rd(2'd1, d); chk("R7 control after wrap", d, 8'h80);
    wr(2'd0, 16'h5A77);
    wr(2'd2, 16'h0000);
    wr(2'd1, 16'hA527);
    rd(2'd0, d); chk("R8 count locked", d, 0);
    rd(2'd2, d); chk("R8 reset-control locked", d, 1);
    rd(2'd1, d); chk("R8 control locked", d, 8'h80);   // read while low
    wait_idle();
    chk("R5 low width 132 ticks", last_low, 264);
    chk("R6 reset width", last_rst, 518);
    wr(2'd1, 16'hA500);
    rd(2'd1, d); chk("R9 low-window read did not arm", d, 8'h80);
    wr(2'd1, 16'hA580);
    rd(2'd1, d); chk("R10 write 1 keeps flag", d, 8'h80);
    wr(2'd1, 16'hA500);
    rd(2'd1, d); chk("R10 read then write 0 clears", d, 8'h00);

    // R7 watchdog wrap with reset disabled
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'h5AF0);
    rst_seen = 0;
    wr(2'd1, 16'hA563);
    wr(2'd1, 16'hA560);
    wr(2'd0, 16'h5AF0);
    wait_low(ok);
    chk("R7 overflow line fell", ok, 1);
    rd(2'd0, d); chk("R7 count cleared", d, 0);
    rd(2'd1, d); chk("R7 control cleared", d, 8'h80);
    wait_idle();
    chk("R7 no reset request", rst_seen, 0);
    rd(2'd1, d);
    wr(2'd1, 16'hA500);

    // R12 low-power arbitration
    wr(2'd0, 16'h5A00);
    sby_sel = 1'b1;
    wr(2'd1, 16'hA520);
    @(negedge clk); sleep_req = 1'b1; #1;
    chk("R12 interval run -> standby", {sleep_o, standby_o}, 2'b01);
    wr(2'd1, 16'hA560);
    #1 chk("R12 watchdog run -> sleep", {sleep_o, standby_o}, 2'b10);
    wr(2'd1, 16'hA540);
    #1 chk("R12 watchdog stopped -> standby", {sleep_o, standby_o}, 2'b01);
    sby_sel = 1'b0; #1;
    chk("R12 no standby select -> sleep", {sleep_o, standby_o}, 2'b10);
    sleep_req = 1'b0; #1;
    chk("R12 no request", {sleep_o, standby_o}, 2'b00);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule